// File: doc/BRIEF.md
# Dual PLL Bring-Up Sequencer

This block brings two on-chip PLLs, one for the processor clock and one for the memory clock, from reset into locked operation. It talks to the clock-generation registers through a simple single-access register port, and software only gives it a start pulse. Before it touches the PLLs it places the processor, memory and bus clocks in bypass. It then writes both PLL configuration words with the power-down bit set, and runs a calibration pass on each PLL in turn.

A calibration pass writes a fixed burst of five words into that PLL's four-word calibration window. It then toggles a calibration bit with settle waits, polls a completion flag with a timeout, and reads back a 20-bit measurement. If the measurement is out of range, the whole pass repeats from its first write. When both PLLs have passed, the block removes bypass one clock at a time and programs both dither registers. All waits are counted in cycles of the block's clock, which is the reference clock. The divider values arrive ready-made as input words.

Top module: `pll_bringup_seq`

## Requirements
- R1: After reset and whenever idle, `busy`, `done` and `timeout_err` are low and neither `bus_wr` nor `bus_rd` is asserted.
- R2: The first calibration word, written at window offset 0x0, is taken from `strap_40m` as sampled at start. When the strap is 1, the word is 0x41C00000 for the processor PLL and 0x41680000 for the memory PLL. When the strap is 0, the words are 0x29C00000 and 0x29680000.
- R3: On start, bits 2, 3 and 4 of the clock-control register are set one at a time. Each is set by a read followed by a write that keeps all other bits. The processor configuration word and then the memory configuration word are written, each ORed with bit 30 (power-down). All later PLL accesses happen while the three bypass bits are set.
- R4: Each pass begins with five writes into the PLL's window, in this order: 0x10810F00 at +0x4, the initial word at +0x0, 0xD0810F00 at +0x4, 0x03000000 at +0x8, and 0xD0800F00 at +0x4.
- R5: After the burst, bit 30 of +0x8 is cleared, then SETTLE_CYC cycles pass. The bit is set, and SETTLE_CYC cycles pass. After polling, bit 30 is cleared again and SETTLE_CYC cycles pass. Each change is a read-modify-write.
- R6: The block reads +0xC until bit 3 reads 1. If POLL_CYC cycles pass without that, the next completed read ends the poll and sets `timeout_err`. `timeout_err` stays set until the next start, and the sequence still continues.
- R7: The block reads +0x8 and takes bits 22:3. A value of 0x40000 or more restarts the pass at its first write. A value of 0x3FFFF or less accepts the pass.
- R8: The processor PLL pass completes before the memory PLL pass begins. After both, bypass bits 2, 3 and 4 are cleared in that order, each by a read-modify-write that keeps the other bits.
- R9: The last two writes are 0x78100000 to the memory dither register, then 0x00C00000 to the processor dither register.
- R10: `busy` is high from the cycle after start until the final write. `done` is a one-cycle pulse as `busy` falls. A start while busy is ignored.
- R11: A request holds `bus_wr` or `bus_rd`, the address and the write data unchanged until `bus_ready` is sampled high. `bus_wr` and `bus_rd` are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to run the sequence |
| strap_40m | input | 1 | 1 when the reference is 40 MHz |
| cpu_cfg_word | input | 32 | Processor PLL configuration word |
| ddr_cfg_word | input | 32 | Memory PLL configuration word |
| bus_wr | output | 1 | Write request |
| bus_rd | output | 1 | Read request |
| bus_addr | output | ADDR_W | Register byte address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid when `bus_ready` is high |
| bus_ready | input | 1 | Current access completes at this edge |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout_err | output | 1 | Sticky poll-timeout flag |

## Verification
Each run drives a behavioural PLL model and compares every write the block issues, in order, against a list built from the requirements. The runs differ in strap value, in the number of out-of-range measurements per PLL, in poll delay, in bus wait states, and in which PLL never reports completion. Retries that return exactly 0x40000 and then 0x3FFFF separate the boundary of the range check. A timeout run on each PLL, with a clean run between them, shows that the error flag is sticky, cleared by the next start, and does not stop the sequence. Wait states show whether requests are held through a stall. A start pulse during a run shows whether a second sequence is kept out.

// File: rtl/pll_bringup_seq.sv
module pll_bringup_seq #(
  parameter int ADDR_W     = 12,
  parameter int SETTLE_CYC = 125,
  parameter int POLL_CYC   = 250000,
  parameter bit [ADDR_W-1:0] CFG_CPU_ADDR = 'h010,
  parameter bit [ADDR_W-1:0] CFG_DDR_ADDR = 'h014,
  parameter bit [ADDR_W-1:0] CLK_CTL_ADDR = 'h018,
  parameter bit [ADDR_W-1:0] DIT_DDR_ADDR = 'h01C,
  parameter bit [ADDR_W-1:0] DIT_CPU_ADDR = 'h020,
  parameter bit [ADDR_W-1:0] CAL_CPU_BASE = 'h100,
  parameter bit [ADDR_W-1:0] CAL_DDR_BASE = 'h200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              strap_40m,
  input  logic [31:0]       cpu_cfg_word,
  input  logic [31:0]       ddr_cfg_word,
  output logic              bus_wr,
  output logic              bus_rd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [31:0]       bus_wdata,
  input  logic [31:0]       bus_rdata,
  input  logic              bus_ready,
  output logic              busy,
  output logic              done,
  output logic              timeout_err
);
  localparam int CNT_MAX = (SETTLE_CYC > POLL_CYC) ? SETTLE_CYC : POLL_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [4:0] ST_PASS = 5'd5, ST_UNBYP = 5'd18, ST_LAST = 5'd22;
  localparam logic [31:0] BIT30 = 32'h4000_0000;

  typedef enum logic [2:0] {OP_WR, OP_SET, OP_CLR, OP_WAIT, OP_POLL, OP_CHK} op_e;

  logic [4:0]       step;
  logic             ph, pll, strap_q;
  logic [CNT_W-1:0] cnt;
  logic [31:0]      hold, cpu_q, ddr_q;
  op_e              op;
  logic [31:0]      val;

  wire [ADDR_W-1:0] cal  = pll ? CAL_DDR_BASE : CAL_CPU_BASE;
  wire [31:0]       init = pll ? (strap_q ? 32'h4168_0000 : 32'h2968_0000)
                               : (strap_q ? 32'h41C0_0000 : 32'h29C0_0000);

  always_comb begin
    op = OP_WR; bus_addr = cal; val = '0;
    case (step)
      5'd0, 5'd1, 5'd2: begin op = OP_SET; bus_addr = CLK_CTL_ADDR; val = 32'd4 << step; end
      5'd3:  begin bus_addr = CFG_CPU_ADDR; val = cpu_q | BIT30; end
      5'd4:  begin bus_addr = CFG_DDR_ADDR; val = ddr_q | BIT30; end
      5'd5:  begin bus_addr = cal + ADDR_W'(4); val = 32'h1081_0F00; end
      5'd6:  val = init;
      5'd7:  begin bus_addr = cal + ADDR_W'(4); val = 32'hD081_0F00; end
      5'd8:  begin bus_addr = cal + ADDR_W'(8); val = 32'h0300_0000; end
      5'd9:  begin bus_addr = cal + ADDR_W'(4); val = 32'hD080_0F00; end
      5'd10, 5'd15: begin op = OP_CLR; bus_addr = cal + ADDR_W'(8); val = BIT30; end
      5'd12: begin op = OP_SET; bus_addr = cal + ADDR_W'(8); val = BIT30; end
      5'd11, 5'd13, 5'd16: op = OP_WAIT;
      5'd14: begin op = OP_POLL; bus_addr = cal + ADDR_W'(12); end
      5'd17: begin op = OP_CHK; bus_addr = cal + ADDR_W'(8); end
      5'd18, 5'd19, 5'd20: begin op = OP_CLR; bus_addr = CLK_CTL_ADDR; val = 32'd4 << (step - 5'd18); end
      5'd21: begin bus_addr = DIT_DDR_ADDR; val = 32'h7810_0000; end
      default: begin bus_addr = DIT_CPU_ADDR; val = 32'h00C0_0000; end
    endcase
  end

  wire rmw = (op == OP_SET) || (op == OP_CLR);
  assign bus_wr    = busy && ((op == OP_WR) || (rmw && ph));
  assign bus_rd    = busy && ((rmw && !ph) || (op == OP_POLL) || (op == OP_CHK));
  assign bus_wdata = (op == OP_WR) ? val : (op == OP_SET) ? (hold | val) : (hold & ~val);

  wire meas_bad = bus_rdata[22:3] >= 20'h40000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; timeout_err <= 1'b0;
      step <= '0; ph <= 1'b0; pll <= 1'b0; cnt <= '0; hold <= '0;
      strap_q <= 1'b0; cpu_q <= '0; ddr_q <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1; step <= '0; ph <= 1'b0; pll <= 1'b0; cnt <= '0;
          timeout_err <= 1'b0; strap_q <= strap_40m;
          cpu_q <= cpu_cfg_word; ddr_q <= ddr_cfg_word;
        end
      end else begin
        case (op)
          OP_WR:
            if (bus_ready) begin
              if (step == ST_LAST) begin busy <= 1'b0; done <= 1'b1; end
              else step <= step + 5'd1;
            end
          OP_SET, OP_CLR:
            if (bus_ready) begin
              if (!ph) begin hold <= bus_rdata; ph <= 1'b1; end
              else begin ph <= 1'b0; step <= step + 5'd1; end
            end
          OP_WAIT:
            if (cnt == CNT_W'(SETTLE_CYC - 1)) begin cnt <= '0; step <= step + 5'd1; end
            else cnt <= cnt + 1'b1;
          OP_POLL: begin
            if (bus_ready && (bus_rdata[3] || cnt >= CNT_W'(POLL_CYC - 1))) begin
              if (!bus_rdata[3]) timeout_err <= 1'b1;
              cnt <= '0; step <= step + 5'd1;
            end else if (cnt < CNT_W'(POLL_CYC - 1)) cnt <= cnt + 1'b1;
          end
          default:
            if (bus_ready) begin
              if (meas_bad) step <= ST_PASS;
              else if (!pll) begin pll <= 1'b1; step <= ST_PASS; end
              else step <= ST_UNBYP;
            end
        endcase
      end
    end
  end
endmodule

module pll_bringup_seq_chk #(parameter int ADDR_W = 12) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              bus_ready,
  input logic              busy,
  input logic              done,
  input logic              timeout_err
);
  AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(bus_wr && bus_rd)); // R11
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_wr || bus_rd) && !bus_ready) |=> (bus_wr == $past(bus_wr)) && (bus_rd == $past(bus_rd))
      && $stable(bus_addr) && $stable(bus_wdata)); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !bus_wr && !bus_rd); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy && $past(busy)); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (busy && timeout_err) |=> timeout_err); // R6
endmodule

bind pll_bringup_seq pll_bringup_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/pll_bringup_seq_bench.sv
module pll_bringup_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE = 3;
  localparam int POLLC  = 12;
  localparam logic [31:0] CLK_PRESET = 32'h0000_0123;

  typedef struct packed {
    logic       strap;
    logic [2:0] fail_cpu;
    logic [2:0] fail_ddr;
    logic       to_cpu;
    logic       to_ddr;
    logic [2:0] pdelay;
    logic [1:0] wst;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'd0, 3'd0, 1'b0, 1'b0, 3'd2, 2'd0},
    '{1'b1, 3'd0, 3'd0, 1'b0, 1'b0, 3'd0, 2'd1},
    '{1'b1, 3'd2, 3'd0, 1'b0, 1'b0, 3'd1, 2'd0},
    '{1'b0, 3'd0, 3'd1, 1'b0, 1'b0, 3'd3, 2'd2},
    '{1'b0, 3'd0, 3'd0, 1'b1, 1'b0, 3'd0, 2'd0},
    '{1'b1, 3'd1, 3'd1, 1'b0, 1'b0, 3'd1, 2'd1},
    '{1'b1, 3'd1, 3'd0, 1'b0, 1'b1, 3'd2, 2'd0}
  };

  logic clk = 0, rst_n = 0, start = 0, strap_40m = 0;
  logic [31:0] cpu_cfg_word = 0, ddr_cfg_word = 0, bus_rdata = 0, bus_wdata;
  logic bus_ready = 0, bus_wr, bus_rd, busy, done, timeout_err;
  logic [11:0] bus_addr;

  pll_bringup_seq #(.SETTLE_CYC(SETTLE), .POLL_CYC(POLLC)) u_pll_bringup_seq (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  vec_t cur;
  logic [31:0] clk_reg;
  logic [31:0] cal8 [2];
  int attempt [2], pcnt [2];
  logic polled [2];
  int wcnt = 0;
  int nlog = 0, nexp = 0, dones = 0, byp_viol = 0;
  logic [11:0] log_a [128], exp_a [128];
  logic [31:0] log_d [128], exp_d [128];

  function automatic int pidx(input logic [11:0] a);
    return (a[11:4] == 8'h20) ? 1 : 0;
  endfunction

  function automatic logic [19:0] meas(input int p);
    logic [2:0] f;
    f = p ? cur.fail_ddr : cur.fail_cpu;
    return (attempt[p] <= int'(f)) ? 20'h40000 : 20'h3FFFF;
  endfunction

  always @(negedge clk) begin
    logic req, isc;
    int p;
    req = bus_wr || bus_rd;
    isc = (bus_addr[11:4] == 8'h10) || (bus_addr[11:4] == 8'h20);
    p = pidx(bus_addr);
    bus_ready = req && (wcnt == int'(cur.wst));
    bus_rdata = 32'h0;
    if (bus_addr == 12'h018) bus_rdata = clk_reg;
    else if (isc && bus_addr[3:0] == 4'h8)
      bus_rdata = {cal8[p][31:23], polled[p] ? meas(p) : 20'h0, cal8[p][2:0]};
    else if (isc && bus_addr[3:0] == 4'hC)
      bus_rdata = {28'h0, ((p ? !cur.to_ddr : !cur.to_cpu) && pcnt[p] >= int'(cur.pdelay)), 3'b0};
    if (done) dones++;
    if (bus_ready) begin
      wcnt = 0;
      if (bus_rd && isc && bus_addr[3:0] == 4'hC) begin
        if (bus_rdata[3]) polled[p] = 1'b1;
        pcnt[p]++;
      end
      if (bus_wr) begin
        if (nlog < 128) begin log_a[nlog] = bus_addr; log_d[nlog] = bus_wdata; end
        nlog++;
        if (isc && clk_reg[4:2] != 3'b111) byp_viol++;
        if (bus_addr == 12'h018) clk_reg = bus_wdata;
        if (isc && bus_addr[3:0] == 4'h8) cal8[p] = bus_wdata;
        if (isc && bus_addr[3:0] == 4'h0) begin attempt[p]++; pcnt[p] = 0; polled[p] = 1'b0; end
      end
    end else if (req) wcnt++;
  end

  task automatic check(input bit ok, input string req, input string what, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL R10 watchdog expired: actual %0d expected done", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic push(input logic [11:0] a, input logic [31:0] d);
    exp_a[nexp] = a; exp_d[nexp] = d; nexp++;
  endtask

  task automatic build_exp(input vec_t v, input logic [31:0] cw, input logic [31:0] dw);
    logic [31:0] c;
    nexp = 0;
    c = CLK_PRESET;
    for (int b = 2; b <= 4; b++) begin c = c | (32'd1 << b); push(12'h018, c); end // R3
    push(12'h010, cw | 32'h4000_0000);
    push(12'h014, dw | 32'h4000_0000);
    for (int p = 0; p < 2; p++) begin // R8 processor first
      int nf;
      logic [11:0] b;
      logic to;
      nf = p ? int'(v.fail_ddr) : int'(v.fail_cpu);
      to = p ? v.to_ddr : v.to_cpu;
      b  = p ? 12'h200 : 12'h100;
      for (int n = 0; n <= nf; n++) begin
        logic [19:0] m;
        m = to ? 20'h0 : ((n < nf) ? 20'h40000 : 20'h3FFFF); // R7 boundary
        push(b + 12'h4, 32'h1081_0F00); // R4
        push(b, p ? (v.strap ? 32'h4168_0000 : 32'h2968_0000)
                  : (v.strap ? 32'h41C0_0000 : 32'h29C0_0000)); // R2
        push(b + 12'h4, 32'hD081_0F00);
        push(b + 12'h8, 32'h0300_0000);
        push(b + 12'h4, 32'hD080_0F00);
        push(b + 12'h8, 32'h0300_0000); // R5
        push(b + 12'h8, 32'h4300_0000);
        push(b + 12'h8, 32'h0300_0000 | {9'h0, m, 3'h0});
      end
    end
    for (int b = 2; b <= 4; b++) begin c = c & ~(32'd1 << b); push(12'h018, c); end // R8
    push(12'h01C, 32'h7810_0000); // R9
    push(12'h020, 32'h00C0_0000);
  endtask

  task automatic run_vec(input int i, input bit extra_start);
    logic [31:0] cw, dw;
    int first_bad, n;
    cur = VECS[i];
    clk_reg = CLK_PRESET;
    for (int p = 0; p < 2; p++) begin cal8[p] = 0; attempt[p] = 0; pcnt[p] = 0; polled[p] = 0; end
    nlog = 0; dones = 0; byp_viol = 0;
    cw = 32'h0009_1018 + i; dw = 32'h0231_4000 + i;
    build_exp(cur, cw, dw);
    @(negedge clk);
    start = 1; strap_40m = cur.strap; cpu_cfg_word = cw; ddr_cfg_word = dw;
    @(negedge clk);
    start = 0; strap_40m = ~cur.strap; cpu_cfg_word = '0; ddr_cfg_word = '0;
    check(busy, "R10", "busy after start", 32'(busy), 32'd1);
    n = 0;
    while (dones == 0 && n < 5000) begin
      @(negedge clk); n++;
      if (extra_start && n == 40) start = 1;
      if (extra_start && n == 41) start = 0;
    end
    repeat (4) @(negedge clk);
    check(nlog == nexp, "R7", "write count", 32'(nlog), 32'(nexp));
    first_bad = -1;
    for (int k = 0; k < nexp && k < nlog; k++)
      if (first_bad < 0 && (log_a[k] != exp_a[k] || log_d[k] != exp_d[k])) first_bad = k;
    if (first_bad >= 0)
      check(0, "R2/R3/R4/R5/R8/R9", $sformatf("write %0d addr %h", first_bad, log_a[first_bad]),
            log_d[first_bad], exp_d[first_bad]);
    else check(1, "R4", "write order", 0, 0);
    check(timeout_err == (cur.to_cpu || cur.to_ddr), "R6", "timeout flag", 32'(timeout_err),
          32'(cur.to_cpu || cur.to_ddr));
    check(dones == 1, "R10", "done pulses", 32'(dones), 32'd1);
    check(clk_reg == CLK_PRESET, "R8", "clock control after release", clk_reg, CLK_PRESET);
    check(byp_viol == 0, "R3", "PLL access outside bypass", 32'(byp_viol), 32'd0);
    check(!busy && !bus_wr && !bus_rd, "R1", "idle after done", {bus_wr, bus_rd, busy}, 32'd0);
  endtask

  initial begin
    cur = VECS[0];
    repeat (4) @(negedge clk);
    check(!busy && !done && !timeout_err && !bus_wr && !bus_rd, "R1", "reset state",
          {busy, done, timeout_err, bus_wr, bus_rd}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !bus_wr && !bus_rd, "R1", "idle after reset", {busy, bus_wr, bus_rd}, 32'd0);
    for (int i = 0; i < NV; i++) run_vec(i, 1'b0);
    run_vec(2, 1'b1); // R10 start while busy ignored
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule